// File: doc/BRIEF.md
# Predict-Not-Taken Branch Flush Controller

This block steers instruction fetch and squashes wrong-path work for a four-stage in-order pipeline (Fetch, Decode, Execute, Write-back). Fetch always runs down the sequential path, so every branch is in effect predicted not taken. The Execute stage supplies the real outcome of a branch. If that outcome is taken, the block sends fetch to the branch target on the next clock. It also turns the two younger instructions, the one being fetched and the one in Decode, into bubbles that travel to Write-back with their valid bit low.

The block holds the fetch address register. It also holds a small tag pipeline of valid bit, branch flag and address for the Decode, Execute and Write-back slots. Each taken branch adds two to a running penalty counter, so the total lost cycles can be read at the port. The branch outcome and target come straight from the environment. Instruction decode, the ALU, memory, data hazards and stalls are outside this block.

Top module: `npt_flush_ctl`

## Requirements
- R1: While `rstN` is low, `pc` equals the reset address (default 0x100), `decValid`, `exValid` and `wbValid` are 0, and `penaltyCount` is 0.
- R2: With no taken branch, `pc` advances by the instruction size (default 4) on every clock. Each fetched instruction reaches Write-back three clocks after it was fetched, carrying its address on `wbPc`.
- R3: When Execute holds a valid branch (`exValid`=1, `exIsBranch`=1) and `exCond` is 1, then `nextPcSel`, `flushFetch` and `flushDecode` are 1 in that same cycle, and `pc` equals `exTarget` after the next clock.
- R4: After a taken branch, the two instructions that followed it never reach Write-back. `wbValid` is 1 for the branch, 0 for the next two cycles, and 1 for the target instruction in the cycle after that.
- R5: A branch whose `exCond` is 0 raises no flush or redirect. Its successors reach Write-back on consecutive cycles and `penaltyCount` does not change.
- R6: `penaltyCount` rises by exactly 2 on the clock that completes each taken branch and is otherwise unchanged. The counter is 32 bits wide.
- R7: `exCond` is ignored when the Execute slot holds a valid instruction that is not a branch. There is no redirect and no flush, and `pc` keeps stepping sequentially.
- R8: A branch that was squashed by an older taken branch has no effect. It reaches Execute as a bubble, and `exCond`=1 in that cycle causes no redirect and adds no penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchIsBranch | input | 1 | The instruction fetched at `pc` this cycle is a branch |
| exCond | input | 1 | Resolved condition of the branch in Execute (1 = taken) |
| exTarget | input | ADDR_W | Target address of the branch in Execute |
| pc | output | ADDR_W | Current fetch address |
| nextPcSel | output | 1 | 1 = next fetch address is `exTarget`, 0 = sequential |
| flushFetch | output | 1 | Squash the instruction now in Fetch |
| flushDecode | output | 1 | Squash the instruction now in Decode |
| decValid | output | 1 | Decode slot holds a live instruction |
| exValid | output | 1 | Execute slot holds a live instruction |
| exIsBranch | output | 1 | Execute slot holds a branch |
| wbValid | output | 1 | Write-back slot holds a live instruction |
| wbIsBranch | output | 1 | Write-back slot holds a branch |
| wbPc | output | ADDR_W | Address of the instruction in Write-back |
| penaltyCount | output | CNT_W | Accumulated branch penalty cycles |

## Verification
The redirect select and both flush strobes are combinational on the Execute slot and `exCond`. They are checked one time unit after the inputs change, in the same cycle. The fetch address, the Decode and Execute valid bits and the penalty counter are checked one clock after resolution. The Write-back slot is checked over the three clocks that follow, because each bubble needs that long to drain. All inputs are driven and all outputs sampled on the falling edge. Each scenario task counts edges from the cycle in which it fetched the branch, so every expected value is tied to a known clock.

// File: rtl/npt_pkg.sv
package npt_pkg;

  // Strobes sent from the resolution logic to the datapath.
  typedef struct packed {
    logic redirect;    // load branch target into the fetch address
    logic killFetch;   // instruction entering Decode becomes a bubble
    logic killDecode;  // instruction entering Execute becomes a bubble
  } ctlStrobesT;

  // Index of each tag register behind Fetch.
  localparam int SLOT_DEC = 0;
  localparam int SLOT_EX  = 1;
  localparam int SLOT_WB  = 2;
  localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/npt_datapath.sv
module npt_datapath
  import npt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        strobes,
  input  logic              fetchIsBranch,
  input  logic [ADDR_W-1:0] exTarget,
  output logic [ADDR_W-1:0] pc,
  output logic              decValid,
  output logic              exValid,
  output logic              exIsBranch,
  output logic              wbValid,
  output logic              wbIsBranch,
  output logic [ADDR_W-1:0] wbPc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] pcNext;
  logic [NUM_SLOTS-1:0] slotValid;
  logic [NUM_SLOTS-1:0] slotBranch;
  logic [ADDR_W-1:0]    slotPc [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] killIn;
  assign killIn = {1'b0, strobes.killDecode, strobes.killFetch};

  assign pcNext = strobes.redirect ? exTarget : pc + STEP;

  always_ff @(posedge clk) begin
    if (!rstN) pc <= RESET_PC;
    else       pc <= pcNext;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic              inValid;
    logic              inBranch;
    logic [ADDR_W-1:0] inPc;
    if (s == 0) begin : g_src_fetch
      assign inValid  = 1'b1;
      assign inBranch = fetchIsBranch;
      assign inPc     = pc;
    end else begin : g_src_prev
      assign inValid  = slotValid[s-1];
      assign inBranch = slotBranch[s-1];
      assign inPc     = slotPc[s-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[s]  <= 1'b0;
        slotBranch[s] <= 1'b0;
        slotPc[s]     <= '0;
      end else begin
        slotValid[s]  <= inValid & ~killIn[s];
        slotBranch[s] <= inBranch & ~killIn[s];
        slotPc[s]     <= inPc;
      end
    end
  end

  assign decValid   = slotValid[SLOT_DEC];
  assign exValid    = slotValid[SLOT_EX];
  assign exIsBranch = slotBranch[SLOT_EX];
  assign wbValid    = slotValid[SLOT_WB];
  assign wbIsBranch = slotBranch[SLOT_WB];
  assign wbPc       = slotPc[SLOT_WB];

endmodule

// File: rtl/npt_ctrl.sv
module npt_ctrl
  import npt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             exValid,
  input  logic             exIsBranch,
  input  logic             exCond,
  output ctlStrobesT       strobes,
  output logic [CNT_W-1:0] penaltyCount
);

  // Outcome known in Execute: everything fetched after the branch and
  // ahead of Execute is lost, one cycle per slot.
  localparam int RESOLVE_SLOT = SLOT_EX + 1;
  localparam logic [CNT_W-1:0] PENALTY = CNT_W'(RESOLVE_SLOT);

  logic taken;

  assign taken = exValid & exIsBranch & exCond;

  always_comb begin
    strobes            = '0;
    strobes.redirect   = taken;
    strobes.killFetch  = taken;
    strobes.killDecode = taken;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      penaltyCount <= '0;
    else if (taken) penaltyCount <= penaltyCount + PENALTY;
  end

endmodule

// File: rtl/npt_flush_ctl.sv
module npt_flush_ctl
  import npt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter int CNT_W      = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchIsBranch,
  input  logic              exCond,
  input  logic [ADDR_W-1:0] exTarget,
  output logic [ADDR_W-1:0] pc,
  output logic              nextPcSel,
  output logic              flushFetch,
  output logic              flushDecode,
  output logic              decValid,
  output logic              exValid,
  output logic              exIsBranch,
  output logic              wbValid,
  output logic              wbIsBranch,
  output logic [ADDR_W-1:0] wbPc,
  output logic [CNT_W-1:0]  penaltyCount
);

  ctlStrobesT strobes;

  npt_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .exValid      (exValid),
    .exIsBranch   (exIsBranch),
    .exCond       (exCond),
    .strobes      (strobes),
    .penaltyCount (penaltyCount)
  );

  npt_datapath #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES),
    .RESET_PC   (RESET_PC)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .fetchIsBranch (fetchIsBranch),
    .exTarget      (exTarget),
    .pc            (pc),
    .decValid      (decValid),
    .exValid       (exValid),
    .exIsBranch    (exIsBranch),
    .wbValid       (wbValid),
    .wbIsBranch    (wbIsBranch),
    .wbPc          (wbPc)
  );

  assign nextPcSel   = strobes.redirect;
  assign flushFetch  = strobes.killFetch;
  assign flushDecode = strobes.killDecode;

endmodule

// File: rtl/npt_flush_ctl_chk.sv
module npt_flush_ctl_chk #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter int CNT_W      = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              exCond,
  input logic [ADDR_W-1:0] exTarget,
  input logic [ADDR_W-1:0] pc,
  input logic              nextPcSel,
  input logic              flushFetch,
  input logic              flushDecode,
  input logic              decValid,
  input logic              exValid,
  input logic              exIsBranch,
  input logic [CNT_W-1:0]  penaltyCount
);

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    nextPcSel |=> pc == $past(exTarget)); // R3

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    !nextPcSel |=> pc == $past(pc) + ADDR_W'(INSN_BYTES)); // R2

  AST_YOUNGER_SQUASHED: assert property (@(posedge clk) disable iff (!rstN)
    flushFetch && flushDecode |=> !decValid && !exValid); // R4

  AST_PENALTY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    nextPcSel |=> penaltyCount == $past(penaltyCount) + CNT_W'(2)); // R6

  AST_PENALTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !nextPcSel |=> $stable(penaltyCount)); // R5

  AST_FLUSH_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    flushDecode |-> exValid && exIsBranch && exCond); // R7

  AST_NO_FLUSH_ON_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    !exValid |-> !flushFetch && !nextPcSel); // R8

endmodule

bind npt_flush_ctl npt_flush_ctl_chk #(
  .ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_npt_flush_ctl.sv
module test_npt_flush_ctl;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 32;
  localparam logic [31:0] RST_PC = 32'h100;
  localparam logic [31:0] STEP   = 32'd4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchIsBranch = 1'b0;
  logic        exCond = 1'b0;
  logic [31:0] exTarget = '0;
  logic [31:0] pc;
  logic        nextPcSel, flushFetch, flushDecode;
  logic        decValid, exValid, exIsBranch, wbValid, wbIsBranch;
  logic [31:0] wbPc;
  logic [31:0] penaltyCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] expCount = '0;

  always #2 clk = ~clk;

  npt_flush_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_PC(RST_PC)) i_npt_flush_ctl (
    .clk(clk), .rstN(rstN), .fetchIsBranch(fetchIsBranch), .exCond(exCond),
    .exTarget(exTarget), .pc(pc), .nextPcSel(nextPcSel), .flushFetch(flushFetch),
    .flushDecode(flushDecode), .decValid(decValid), .exValid(exValid),
    .exIsBranch(exIsBranch), .wbValid(wbValid), .wbIsBranch(wbIsBranch),
    .wbPc(wbPc), .penaltyCount(penaltyCount)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1", "pc", pc, RST_PC);
    check("R1", "valids", {29'd0, decValid, exValid, wbValid}, 32'd0);
    check("R1", "penalty", penaltyCount, 32'd0);
    rstN = 1'b1;
  endtask

  task automatic test_sequential();
    logic [31:0] p0;
    p0 = pc;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R2", "pc step", pc, p0 + STEP * i);
    end
    // first fetched address reached Write-back after three edges
    check("R2", "wbPc", wbPc, p0 + STEP);
    check("R2", "wbValid", {31'd0, wbValid}, 32'd1);
  endtask

  task automatic test_taken(input logic [31:0] tgt, input bit nextIsBranch);
    logic [31:0] p;
    @(negedge clk); p = pc; fetchIsBranch = 1'b1;
    @(negedge clk); fetchIsBranch = nextIsBranch;
    @(negedge clk); fetchIsBranch = 1'b0;
    check("R3", "branch in Execute", {30'd0, exValid, exIsBranch}, 32'd3);
    exCond = 1'b1; exTarget = tgt; #1;
    check("R3", "select/flushes", {29'd0, nextPcSel, flushFetch, flushDecode}, 32'd7);
    @(negedge clk);
    expCount += 2;
    exCond = nextIsBranch;  // R8: squashed branch would be in Execute now
    #1;
    check("R3", "pc at target", pc, tgt);
    check("R4", "dec/ex bubbles", {30'd0, decValid, exValid}, 32'd0);
    check("R4", "branch in Write-back", {31'd0, wbValid}, 32'd1);
    check("R4", "branch wbPc", wbPc, p);
    check("R6", "penalty +2", penaltyCount, expCount);
    check("R8", "no redirect from bubble", {31'd0, nextPcSel}, 32'd0);
    @(negedge clk); exCond = 1'b0;
    check("R8", "pc sequential after bubble", pc, tgt + STEP);
    check("R6", "penalty held", penaltyCount, expCount);
    check("R4", "first bubble in Write-back", {31'd0, wbValid}, 32'd0);
    @(negedge clk);
    check("R4", "second bubble in Write-back", {31'd0, wbValid}, 32'd0);
    @(negedge clk);
    check("R4", "target in Write-back", {31'd0, wbValid}, 32'd1);
    check("R4", "target wbPc", wbPc, tgt);
  endtask

  task automatic test_not_taken();
    logic [31:0] p;
    @(negedge clk); p = pc; fetchIsBranch = 1'b1;
    @(negedge clk); fetchIsBranch = 1'b0;
    @(negedge clk);
    exCond = 1'b0; exTarget = 32'hDEAD_0000; #1;
    check("R5", "no select/flush", {29'd0, nextPcSel, flushFetch, flushDecode}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R5", "successor wbValid", {31'd0, wbValid}, 32'd1);
      check("R5", "successor wbPc", wbPc, p + STEP * i);
    end
    check("R5", "pc sequential", pc, p + STEP * 5);
    check("R5", "penalty unchanged", penaltyCount, expCount);
  endtask

  task automatic test_cond_on_plain();
    logic [31:0] p;
    @(negedge clk);
    check("R7", "Execute holds plain insn", {30'd0, exValid, exIsBranch}, 32'd2);
    p = pc; exCond = 1'b1; exTarget = 32'h0000_BEE0; #1;
    check("R7", "no select/flush", {29'd0, nextPcSel, flushFetch, flushDecode}, 32'd0);
    @(negedge clk); exCond = 1'b0;
    check("R7", "pc sequential", pc, p + STEP);
    check("R7", "penalty unchanged", penaltyCount, expCount);
  endtask

  initial begin
    test_reset();
    test_sequential();
    test_taken(32'h0000_2000, 1'b0);
    test_not_taken();
    test_taken(32'h0000_3000, 1'b1);
    test_cond_on_plain();
    test_taken(32'h0000_4000, 1'b0);
    test_taken(32'h0000_5000, 1'b0);
    check("R6", "total penalty", penaltyCount, 32'd8);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule